// File: doc/BRIEF.md
# Windowed PWM Duty-Cycle Capture

This block measures, for each of several digital input channels, what fraction of a measurement window the input spent at its active level. The window is a whole number of clock cycles taken from an input. It corresponds to one simulation step period. At the end of every window the block publishes one unsigned Q0.16 duty value per channel together with a one-cycle valid strobe. The published values stay unchanged until the next window ends.

Every input passes through a two-stage synchronizer. It is then adjusted for its active level and counted on sample-enable pulses. The sample counter is held to at most 4096 samples per window. The sample interval therefore grows by one clock for each further multiple of 4096 cycles in the window. Short windows are sampled on every clock. Long windows are sampled every `ceil(window/4096)` clocks, so the counters keep a fixed width whatever the step length.

The active level can be chosen per channel. A single shared setting can also apply to all channels.

Top module: `pwm_duty_capture`

## Requirements
- R1: While reset is asserted, and right after it, every duty field of `duty_out` reads 0 and `duty_valid` is low.
- R2: The effective window length is W = `win_len`, or 1 when `win_len` is 0. It is latched at reset and at each window start. `duty_valid` pulses high for exactly one cycle every W clocks.
- R3: The duty of a channel is floor(A * 65536 / T), where A is the number of active samples and T is the total number of samples in the window just ended. The result saturates at 0xFFFF, so an always-active input reads 0xFFFF and a never-active input reads 0x0000.
- R4: With polarity bit i = 0, channel i counts samples where the input is 1. With polarity bit i = 1, it counts samples where the input is 0.
- R5: When `pol_common` is 1, polarity bit 0 applies to every channel and the other polarity bits have no effect.
- R6: The sample divisor is D = ceil(W / 4096). A sample is taken on the cycles whose index within the window (counted from 0) satisfies index mod D = D-1. No window therefore holds more than 4096 samples.
- R7: The level counted at a clock edge is the pin value captured two edges earlier. A pin change made just before edge e first shows up in a result published at edge e+2.
- R8: Channel i occupies bits [16i+15:16i] of `duty_out`. The whole of `duty_out` holds its value in every cycle in which `duty_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwm_in | input | NCH | Asynchronous digital inputs, one per channel |
| pol_low | input | NCH | Per-channel active level (1 = low-active) |
| pol_common | input | 1 | When 1, bit 0 of `pol_low` sets the level for all channels |
| win_len | input | WIN_W | Window length in clock cycles (0 is treated as 1) |
| duty_out | output | 16*NCH | Packed Q0.16 duty results, channel 0 in the low bits |
| duty_valid | output | 1 | One-cycle pulse when new results are published |

## Verification
The bench tests window lengths just below and just above the 4096-cycle step. It uses a pin that toggles every clock. With D = 2 this gives only 0 or full scale, while a design that kept sampling every clock would report about one half. The bench also tests a zero window, which must pulse `duty_valid` on every cycle. A design that took zero literally would either hang or divide by zero. The always-active case must read exactly 0xFFFF rather than wrapping to 0. The bench also tests the two-edge latency through the synchronizer, since a missing or extra stage moves a step change into the wrong window. Finally, it switches between shared and per-channel polarity. It also changes the window length mid-window, and the new length must take effect only at the next boundary.

// File: rtl/pwm_cap_pkg.sv
package pwm_cap_pkg;

  localparam int DUTY_W = 16;

  // Q0.16 ratio of active samples over total samples, saturated at full scale.
  function automatic logic [DUTY_W-1:0] duty_q16(input logic [31:0] act,
                                                 input logic [31:0] tot);
    logic [47:0] num;
    logic [47:0] quo;
    if (tot == 32'd0) return '0;
    num = {act, 16'h0000};
    quo = num / {16'h0000, tot};
    if (quo > 48'h0000_0000_FFFF) return 16'hFFFF;
    return quo[DUTY_W-1:0];
  endfunction

endpackage

// File: rtl/pwm_cap_sync.sv
module pwm_cap_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);

  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= d_async;
      stage2 <= stage1;
    end
  end

  assign q_sync = stage2;

endmodule

// File: rtl/pwm_cap_timebase.sv
module pwm_cap_timebase #(
  parameter int WIN_W    = 24,
  parameter int THR_LOG2 = 12,
  parameter int CNT_W    = THR_LOG2 + 1,
  parameter int DIV_W    = WIN_W - THR_LOG2 + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIN_W-1:0] win_len,
  output logic             win_done,
  output logic             smp_en,
  output logic [CNT_W-1:0] tot_cnt,
  output logic [CNT_W-1:0] tot_nxt
);

  // A zero length behaves as a one-cycle window.
  function automatic logic [WIN_W-1:0] eff_len(input logic [WIN_W-1:0] len);
    return (len == '0) ? WIN_W'(1) : len;
  endfunction

  // ceil(len / 2**THR_LOG2): the number of clocks between samples.
  function automatic logic [DIV_W-1:0] calc_div(input logic [WIN_W-1:0] len);
    logic [WIN_W:0] sum;
    sum = {1'b0, len} + (WIN_W+1)'((2 ** THR_LOG2) - 1);
    return sum[WIN_W:THR_LOG2];
  endfunction

  logic [WIN_W-1:0] cur_len;
  logic [WIN_W-1:0] win_cnt;
  logic [DIV_W-1:0] cur_div;
  logic [DIV_W-1:0] pre_cnt;
  logic [WIN_W-1:0] len_next;

  assign len_next = eff_len(win_len);
  assign win_done = (win_cnt == cur_len - WIN_W'(1));
  assign smp_en   = (pre_cnt == cur_div - DIV_W'(1));
  assign tot_nxt  = tot_cnt + CNT_W'(smp_en);

  always_ff @(posedge clk) begin
    if (!rst_n || win_done) begin
      cur_len <= len_next;
      cur_div <= calc_div(len_next);
      win_cnt <= '0;
      pre_cnt <= '0;
      tot_cnt <= '0;
    end else begin
      win_cnt <= win_cnt + WIN_W'(1);
      pre_cnt <= smp_en ? '0 : pre_cnt + DIV_W'(1);
      tot_cnt <= tot_nxt;
    end
  end

endmodule

// File: rtl/pwm_cap_chan.sv
module pwm_cap_chan #(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lvl_active,
  input  logic             smp_en,
  input  logic             win_done,
  input  logic [CNT_W-1:0] tot_nxt,
  output logic [CNT_W-1:0] act_nxt,
  output logic [pwm_cap_pkg::DUTY_W-1:0] duty
);

  logic [CNT_W-1:0] act_cnt;

  assign act_nxt = act_cnt + CNT_W'(smp_en & lvl_active);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_cnt <= '0;
      duty    <= '0;
    end else if (win_done) begin
      act_cnt <= '0;
      duty    <= pwm_cap_pkg::duty_q16(32'(act_nxt), 32'(tot_nxt));
    end else begin
      act_cnt <= act_nxt;
    end
  end

endmodule

// File: rtl/pwm_duty_capture.sv
module pwm_duty_capture #(
  parameter int NCH      = 4,
  parameter int WIN_W    = 24,
  parameter int THR_LOG2 = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NCH-1:0]      pwm_in,
  input  logic [NCH-1:0]      pol_low,
  input  logic                pol_common,
  input  logic [WIN_W-1:0]    win_len,
  output logic [16*NCH-1:0]   duty_out,
  output logic                duty_valid
);

  localparam int CNT_W = THR_LOG2 + 1;
  localparam int DIV_W = WIN_W - THR_LOG2 + 1;
  localparam int DW    = pwm_cap_pkg::DUTY_W;

  // Named internal events, brought out for the bound checker.
  logic                 win_done;
  logic                 smp_en;
  logic [CNT_W-1:0]     tot_cnt;
  logic [CNT_W-1:0]     tot_nxt;
  logic [NCH-1:0]       pin_sync;
  logic [NCH-1:0]       pol_eff;
  logic [NCH-1:0]       lvl_active;
  logic [NCH*CNT_W-1:0] act_nxt_all;

  pwm_cap_sync #(.W(NCH)) sync_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (pwm_in),
    .q_sync  (pin_sync)
  );

  pwm_cap_timebase #(
    .WIN_W    (WIN_W),
    .THR_LOG2 (THR_LOG2),
    .CNT_W    (CNT_W),
    .DIV_W    (DIV_W)
  ) tb_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .win_len  (win_len),
    .win_done (win_done),
    .smp_en   (smp_en),
    .tot_cnt  (tot_cnt),
    .tot_nxt  (tot_nxt)
  );

  assign pol_eff    = pol_common ? {NCH{pol_low[0]}} : pol_low;
  assign lvl_active = pin_sync ^ pol_eff;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    pwm_cap_chan #(.CNT_W(CNT_W)) chan_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .lvl_active (lvl_active[ch]),
      .smp_en     (smp_en),
      .win_done   (win_done),
      .tot_nxt    (tot_nxt),
      .act_nxt    (act_nxt_all[ch*CNT_W +: CNT_W]),
      .duty       (duty_out[ch*DW +: DW])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) duty_valid <= 1'b0;
    else        duty_valid <= win_done;
  end

endmodule

// File: rtl/pwm_duty_capture_chk.sv
module pwm_duty_capture_chk #(
  parameter int NCH   = 4,
  parameter int CNT_W = 13,
  parameter int THR_LOG2 = 12
) (
  input logic                clk,
  input logic                rst_n,
  input logic                win_done,
  input logic [CNT_W-1:0]    tot_nxt,
  input logic [NCH*CNT_W-1:0] act_nxt_all,
  input logic [16*NCH-1:0]   duty_out,
  input logic                duty_valid
);

  // R2: a boundary is always followed by exactly one publish strobe
  assert_valid_after_boundary_R2: assert property (@(posedge clk) disable iff (!rst_n)
    win_done |=> duty_valid);

  assert_no_stray_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !win_done |=> !duty_valid);

  // R8: results are held between strobes
  assert_hold_between_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!duty_valid && $past(rst_n)) |-> $stable(duty_out));

  // R6: the sample count never exceeds the fixed counter range
  assert_sample_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tot_nxt <= CNT_W'(2 ** THR_LOG2));

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chk
    // R3: all samples active gives exact full scale
    assert_full_scale_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (win_done && act_nxt_all[ch*CNT_W +: CNT_W] == tot_nxt)
      |=> duty_out[ch*16 +: 16] == 16'hFFFF);

    // R3: no active samples gives zero
    assert_zero_scale_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (win_done && act_nxt_all[ch*CNT_W +: CNT_W] == '0)
      |=> duty_out[ch*16 +: 16] == 16'h0000);
  end

endmodule

bind pwm_duty_capture pwm_duty_capture_chk #(
  .NCH      (NCH),
  .CNT_W    (CNT_W),
  .THR_LOG2 (THR_LOG2)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .win_done    (win_done),
  .tot_nxt     (tot_nxt),
  .act_nxt_all (act_nxt_all),
  .duty_out    (duty_out),
  .duty_valid  (duty_valid)
);

// File: tb/pwm_duty_capture_tb_top.sv
module pwm_duty_capture_tb_top;

  localparam int NCH   = 4;
  localparam int WIN_W = 24;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NCH-1:0]    pins = '0;
  logic [NCH-1:0]    pol_low = '0;
  logic              pol_common = 1'b0;
  logic [WIN_W-1:0]  win_len = WIN_W'(8);
  logic [16*NCH-1:0] duty_out;
  logic              duty_valid;

  always #2.5 clk = ~clk;

  pwm_duty_capture #(.NCH(NCH), .WIN_W(WIN_W), .THR_LOG2(12)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwm_in     (pins),
    .pol_low    (pol_low),
    .pol_common (pol_common),
    .win_len    (win_len),
    .duty_out   (duty_out),
    .duty_valid (duty_valid)
  );

  int    checks = 0;
  int    errors = 0;
  string tag = "R1";
  bit    model_on = 1'b0;
  bit    finished = 1'b0;
  int    mode = 1;           // 0 high, 1 low, 2 toggle, 3 random, 4 manual
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_duty(input int a, input int t);
    longint r;
    if (t == 0) return 16'h0;
    r = (longint'(a) * 65536) / t;
    return (r >= 65535) ? 16'hFFFF : 16'(r);
  endfunction

  // Pin stimulus, changed away from the active edge.
  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (mode)
      0: pins <= '1;
      1: pins <= '0;
      2: pins <= ~pins;
      3: pins <= lfsr[NCH-1:0];
      default: ;
    endcase
  end

  // Behavioural reference model.
  logic [NCH-1:0] hist[$];
  int ph, wl, dv, tot;
  int acc[NCH];
  logic [15:0] exp_d[NCH];
  bit exp_v;

  always @(posedge clk) begin
    logic [NCH-1:0] used, lv, pe;
    if (!rst_n) begin
      hist.delete();
      ph = 0; tot = 0; exp_v = 0;
      wl = (win_len == 0) ? 1 : int'(win_len);
      dv = (wl + 4095) / 4096;
      foreach (acc[i]) begin acc[i] = 0; exp_d[i] = 16'h0; end
    end else begin
      used = (hist.size() >= 2) ? hist[hist.size()-2] : '0;
      hist.push_back(pins);
      if (hist.size() > 2) void'(hist.pop_front());
      pe = pol_common ? {NCH{pol_low[0]}} : pol_low;
      lv = used ^ pe;
      if ((ph % dv) == dv - 1) begin
        tot++;
        foreach (acc[i]) acc[i] += int'(lv[i]);
      end
      exp_v = 0;
      if (ph == wl - 1) begin
        exp_v = 1;
        foreach (acc[i]) begin exp_d[i] = ref_duty(acc[i], tot); acc[i] = 0; end
        tot = 0; ph = 0;
        wl = (win_len == 0) ? 1 : int'(win_len);
        dv = (wl + 4095) / 4096;
      end else begin
        ph++;
      end
    end
  end

  // Every-cycle comparison against the model.
  always @(negedge clk) begin
    if (model_on) begin
      chk(duty_valid == exp_v, tag, "valid vs model", duty_valid, exp_v);
      for (int i = 0; i < NCH; i++)
        chk(duty_out[i*16 +: 16] == exp_d[i], tag, $sformatf("ch%0d duty vs model", i),
            duty_out[i*16 +: 16], exp_d[i]);
    end
  end

  task automatic wait_valid();
    int n = 0;
    do begin @(negedge clk); n++; end while (!duty_valid && n < 20000);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    summary();
  end

  initial begin
    int gap;
    logic [15:0] d0;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(duty_out == '0, "R1", "duty in reset", duty_out, 0);
    chk(duty_valid == 1'b0, "R1", "valid in reset", duty_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(duty_out == '0 && !duty_valid, "R1", "after reset", duty_out, 0);
    model_on = 1'b1;

    // R3: always active reads exact full scale, never active reads zero
    tag = "R3"; mode = 0;
    repeat (3) wait_valid();
    chk(duty_out == {NCH{16'hFFFF}}, "R3", "all active full scale", duty_out, {NCH{16'hFFFF}});
    mode = 1;
    repeat (3) wait_valid();
    chk(duty_out == '0, "R3", "never active zero", duty_out, 0);

    // R4: low-active counts zeros; mixed polarity per channel
    tag = "R4"; pol_low = '1;
    repeat (3) wait_valid();
    chk(duty_out == {NCH{16'hFFFF}}, "R4", "low-active on low pins", duty_out, {NCH{16'hFFFF}});
    pol_low = 4'b0101;
    repeat (3) wait_valid();
    chk(duty_out == 64'h0000_FFFF_0000_FFFF, "R4", "mixed polarity", duty_out, 64'h0000_FFFF_0000_FFFF);

    // R5: common polarity overrides the other bits
    tag = "R5"; pol_common = 1'b1; pol_low = 4'b1110;
    repeat (3) wait_valid();
    chk(duty_out == '0, "R5", "common high-active", duty_out, 0);
    pol_low = 4'b0001;
    repeat (3) wait_valid();
    chk(duty_out == {NCH{16'hFFFF}}, "R5", "common low-active", duty_out, {NCH{16'hFFFF}});
    pol_common = 1'b0; pol_low = '0;

    // R2: spacing of strobes, length change takes effect at boundary
    tag = "R2"; mode = 3;
    wait_valid();
    gap = 0;
    do begin @(negedge clk); gap++; end while (!duty_valid && gap < 100);
    chk(gap == 8, "R2", "strobe spacing W=8", gap, 8);
    repeat (3) @(negedge clk);
    win_len = WIN_W'(5);
    repeat (3) wait_valid();
    gap = 0;
    do begin @(negedge clk); gap++; end while (!duty_valid && gap < 100);
    chk(gap == 5, "R2", "strobe spacing W=5", gap, 5);
    win_len = '0;
    repeat (2) wait_valid();
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(duty_valid == 1'b1, "R2", "zero length strobes every cycle", duty_valid, 1);
    end

    // R7: two-edge latency through the synchronizer (W=1)
    tag = "R7"; win_len = WIN_W'(1); mode = 4; pins = '0;
    repeat (6) @(negedge clk);
    pins = '1;
    @(negedge clk);
    chk(duty_out[15:0] == 16'h0, "R7", "one edge after change", duty_out[15:0], 0);
    @(negedge clk);
    chk(duty_out[15:0] == 16'h0, "R7", "two edges after change", duty_out[15:0], 0);
    @(negedge clk);
    chk(duty_out[15:0] == 16'hFFFF, "R7", "three edges after change", duty_out[15:0], 16'hFFFF);

    // R8/R3: random patterns, mid-size window
    tag = "R8"; mode = 3; win_len = WIN_W'(100);
    repeat (4) wait_valid();

    // R6: divisor boundaries
    tag = "R6"; win_len = WIN_W'(4096);
    repeat (2) wait_valid();
    mode = 2; win_len = WIN_W'(4097);
    repeat (3) wait_valid();
    d0 = duty_out[15:0];
    chk(d0 == 16'h0 || d0 == 16'hFFFF, "R6", "toggle at D=2 is 0 or full", d0, 0);
    mode = 3; win_len = WIN_W'(9000);
    repeat (3) wait_valid();
    win_len = WIN_W'(12289);
    repeat (3) wait_valid();

    repeat (4) @(negedge clk);
    summary();
  end

endmodule